// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block is one DMA channel that feeds a small group of peripheral registers from memory. Each transfer is one line of words. A line starts on a rising edge of one peripheral request line, and one word moves on every cycle in which the bus grant is high. The memory-side source address steps by one for every word and is never rewound. The peripheral-side destination address steps by one inside a line. After the last word of a line, a signed offset is added to the destination address, so the next line starts again at the first register of the group. With an offset of -2 the channel cycles over three registers, and with -1 it cycles over two.

Software writes the whole configuration in one load cycle. The configuration holds the two counts, both stored minus one: words per line in the low field and lines per block in the high field. It also holds the two base addresses, the offset, the request select, the memory-space code, the channel enable and the completion-interrupt enable. After the last word of the last line, the channel turns itself off and can pulse its completion interrupt. A request that arrives while a line is still moving is remembered and starts the following line. Arbitration between channels is handled outside this block.

Top module: `dma2d_channel`

## Requirements
- R1: After reset the channel is inactive (`ch_active`=0), `xfer_strobe`=0, `done_irq`=0, and both address outputs are 0.
- R2: When `cfg_load` is high at a clock edge, the channel loads the configuration. `ch_active` then equals `cfg_enable`, `src_addr` equals the source base and `dst_addr` equals the destination base. A channel loaded with enable 0 moves no words, whatever its request line does.
- R3: A line starts only after a 0-to-1 change on `req_lines[cfg_req_sel]`, the line picked by the select value loaded with the configuration. Changes on any other request line have no effect.
- R4: `xfer_strobe` is high only in a cycle in which a line is active and `bus_grant` is high, and each such cycle moves exactly one word. Without a strobe, both address outputs keep their values.
- R5: For each word moved, `src_addr` increases by one (modulo 2^ADDR_W) and never has the offset added.
- R6: For each word moved, `dst_addr` increases by one, except after the last word of a line. At that point the signed two's-complement `cfg_dst_offset` is added instead (0xFFFFFE means -2 and 0xFFFFFF means -1).
- R7: A line is `cfg_words_m1`+1 words long. A block is `cfg_lines_m1`+1 lines long, so it moves (`cfg_words_m1`+1)·(`cfg_lines_m1`+1) words in total.
- R8: A selected request edge that arrives while a line is in progress is held, and it starts the next line after the current one ends. One such request can be held.
- R9: After the last word of the last line, `ch_active` falls. `done_irq` is then high for exactly one cycle if the interrupt enable was loaded as 1, and stays 0 otherwise. No further words move until the next load.
- R10: `mem_space` presents the 2-bit memory-space code loaded with the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the configuration fields this cycle |
| cfg_enable | input | 1 | Channel enable value to load |
| cfg_irq_en | input | 1 | Completion-interrupt enable to load |
| cfg_req_sel | input | SEL_W | Index of the request line that triggers lines |
| cfg_space | input | 2 | Memory-space code |
| cfg_lines_m1 | input | HI_W | Lines per block minus one |
| cfg_words_m1 | input | LO_W | Words per line minus one |
| cfg_src_base | input | ADDR_W | First source (memory) address |
| cfg_dst_base | input | ADDR_W | First destination (peripheral) address |
| cfg_dst_offset | input | ADDR_W | Signed offset added after each line |
| req_lines | input | NUM_REQ | Peripheral request lines |
| bus_grant | input | 1 | Bus granted to this channel this cycle |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| mem_space | output | 2 | Loaded memory-space code |
| xfer_strobe | output | 1 | One word moves this cycle (read/write strobe) |
| ch_active | output | 1 | Channel enabled and not yet finished |
| done_irq | output | 1 | One-cycle block-completion interrupt |

## Verification
The bench goes after line ends and block ends. A design that added the offset one word early or late, or that also offset the source, would show a wrong destination or source address on the strobed word. The bench sends requests in the middle of a line, and a design without the held request would stall forever one line short of the block. Lines of one word and blocks of one line test whether the counters reload correctly, which a design that tests the wrong count at zero gets wrong by moving extra or missing words. Pulses on unselected lines and on a disabled channel, and grant gaps, check that no stray word moves and that the addresses hold.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  // Channel control states
  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,   // disabled or finished
    CH_WAIT = 2'd1,   // enabled, waiting for a request
    CH_LINE = 2'd2    // moving the words of one line
  } ch_state_e;

endpackage

// File: rtl/dma2d_req_detect.sv
module dma2d_req_detect #(
  parameter  int NUM_REQ     = 32,
  parameter  int SYNC_STAGES = 0,
  localparam int SEL_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_lines,
  input  logic [SEL_W-1:0]   sel,
  output logic               rise
);

  logic sel_lvl;
  logic lvl_s;
  logic prev_q;
  logic prev_d;

  assign sel_lvl = req_lines[sel];

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      logic [SYNC_STAGES-1:0] chain_d;

      always_comb begin
        chain_d[0] = sel_lvl;
        for (int i = 1; i < SYNC_STAGES; i++) begin
          chain_d[i] = chain_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end

      assign lvl_s = chain_q[SYNC_STAGES-1];
    end else begin : g_direct
      assign lvl_s = sel_lvl;
    end
  endgenerate

  assign prev_d = lvl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl_s & ~prev_q;

  // R3: an edge is reported for one cycle only
  a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/dma2d_count.sv
module dma2d_count #(
  parameter int LO_W = 12,
  parameter int HI_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LO_W-1:0] lo_init,
  input  logic [HI_W-1:0] hi_init,
  input  logic            step,
  output logic            line_end,
  output logic            block_end
);

  logic [LO_W-1:0] lo_q, lo_d;
  logic [LO_W-1:0] lo_rel_q, lo_rel_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            lo_zero;
  logic            hi_zero;

  assign lo_zero = (lo_q == '0);
  assign hi_zero = (hi_q == '0);

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    lo_rel_d = lo_rel_q;
    if (load) begin
      lo_d     = lo_init;
      hi_d     = hi_init;
      lo_rel_d = lo_init;
    end else if (step) begin
      if (lo_zero) begin
        lo_d = lo_rel_q;
        hi_d = hi_q - HI_W'(1);
      end else begin
        lo_d = lo_q - LO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      lo_rel_q <= '0;
    end else begin
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      lo_rel_q <= lo_rel_d;
    end
  end

  assign line_end  = lo_zero;
  assign block_end = lo_zero & hi_zero;

  // R7: the word counter never exceeds the reload value of a line
  a_r7_lo_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q <= lo_rel_q);

  // R7: after the last word of a line the counter restarts a full line
  a_r7_line_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lo_zero && !load) |=> (lo_q == lo_rel_q));

endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] src_init,
  input  logic [ADDR_W-1:0] dst_init,
  input  logic [ADDR_W-1:0] dst_off,
  input  logic              step,
  input  logic              line_end,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst
);

  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [ADDR_W-1:0] off_q, off_d;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    off_d = off_q;
    if (load) begin
      src_d = src_init;
      dst_d = dst_init;
      off_d = dst_off;
    end else if (step) begin
      src_d = src_q + ADDR_W'(1);
      dst_d = line_end ? (dst_q + off_q) : (dst_q + ADDR_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      off_q <= '0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
      off_q <= off_d;
    end
  end

  assign src = src_q;
  assign dst = dst_q;

  // R5: source steps by exactly one per word
  a_r5_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (src_q == $past(src_q) + ADDR_W'(1)));

  // R4: without a word moved, both addresses hold
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(src_q) && $stable(dst_q)));

  // R6: inside a line the destination steps by one
  a_r6_dst_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !line_end && !load) |=> (dst_q == $past(dst_q) + ADDR_W'(1)));

endmodule

// File: rtl/dma2d_channel.sv
module dma2d_channel
  import dma2d_pkg::*;
#(
  parameter  int NUM_REQ     = 32,
  parameter  int ADDR_W      = 24,
  parameter  int LO_W        = 12,
  parameter  int HI_W        = 12,
  parameter  int SYNC_STAGES = 0,
  localparam int SEL_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic               cfg_enable,
  input  logic               cfg_irq_en,
  input  logic [SEL_W-1:0]   cfg_req_sel,
  input  logic [1:0]         cfg_space,
  input  logic [HI_W-1:0]    cfg_lines_m1,
  input  logic [LO_W-1:0]    cfg_words_m1,
  input  logic [ADDR_W-1:0]  cfg_src_base,
  input  logic [ADDR_W-1:0]  cfg_dst_base,
  input  logic [ADDR_W-1:0]  cfg_dst_offset,
  input  logic [NUM_REQ-1:0] req_lines,
  input  logic               bus_grant,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [1:0]         mem_space,
  output logic               xfer_strobe,
  output logic               ch_active,
  output logic               done_irq
);

  ch_state_e        state_q, state_d;
  logic             pend_q, pend_d;
  logic             irq_q, irq_d;
  logic             irq_en_q, irq_en_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [1:0]       space_q, space_d;
  logic             req_rise;
  logic             line_end;
  logic             block_end;
  logic             xfer;

  dma2d_req_detect #(
    .NUM_REQ    (NUM_REQ),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_lines(req_lines),
    .sel      (sel_q),
    .rise     (req_rise)
  );

  dma2d_count #(
    .LO_W(LO_W),
    .HI_W(HI_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .lo_init  (cfg_words_m1),
    .hi_init  (cfg_lines_m1),
    .step     (xfer),
    .line_end (line_end),
    .block_end(block_end)
  );

  dma2d_addr #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .src_init(cfg_src_base),
    .dst_init(cfg_dst_base),
    .dst_off (cfg_dst_offset),
    .step    (xfer),
    .line_end(line_end),
    .src     (src_addr),
    .dst     (dst_addr)
  );

  assign xfer = (state_q == CH_LINE) & bus_grant;

  // Configuration capture
  always_comb begin
    irq_en_d = irq_en_q;
    sel_d    = sel_q;
    space_d  = space_q;
    if (cfg_load) begin
      irq_en_d = cfg_irq_en;
      sel_d    = cfg_req_sel;
      space_d  = cfg_space;
    end
  end

  // Channel sequencing
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    irq_d   = 1'b0;
    if (cfg_load) begin
      state_d = cfg_enable ? CH_WAIT : CH_OFF;
      pend_d  = 1'b0;
    end else begin
      unique case (state_q)
        CH_WAIT: begin
          if (req_rise || pend_q) begin
            state_d = CH_LINE;
            pend_d  = 1'b0;
          end
        end
        CH_LINE: begin
          if (req_rise) pend_d = 1'b1;
          if (xfer && line_end) begin
            if (block_end) begin
              state_d = CH_OFF;
              pend_d  = 1'b0;
              irq_d   = irq_en_q;
            end else begin
              state_d = CH_WAIT;
            end
          end
        end
        default: begin
          state_d = CH_OFF;
          pend_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CH_OFF;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
      irq_en_q <= 1'b0;
      sel_q    <= '0;
      space_q  <= '0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      irq_q    <= irq_d;
      irq_en_q <= irq_en_d;
      sel_q    <= sel_d;
      space_q  <= space_d;
    end
  end

  assign xfer_strobe = xfer;
  assign ch_active   = (state_q != CH_OFF);
  assign done_irq    = irq_q;
  assign mem_space   = space_q;

  // R9: completion interrupt lasts one cycle
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R9: interrupt only with the channel already off
  a_r9_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !ch_active);

  // R8: a held request starts the next line on the following edge
  a_r8_held_start: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && state_q == CH_WAIT && !cfg_load) |=> (state_q == CH_LINE));

  // R3: with no edge and nothing held, a waiting channel keeps waiting
  a_r3_idle_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_WAIT && !req_rise && !pend_q && !cfg_load)
      |=> (state_q == CH_WAIT));

  // R9: a finished channel stays off until reloaded
  a_r9_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_active && !cfg_load) |=> !ch_active);

endmodule

// File: tb/tb_dma2d_channel.sv
module tb_dma2d_channel;

  localparam int NUM_REQ = 32;
  localparam int ADDR_W  = 24;
  localparam int LO_W    = 12;
  localparam int HI_W    = 12;
  localparam int SEL_W   = 5;

  logic               clk;
  logic               rst_n;
  logic               cfg_load;
  logic               cfg_enable;
  logic               cfg_irq_en;
  logic [SEL_W-1:0]   cfg_req_sel;
  logic [1:0]         cfg_space;
  logic [HI_W-1:0]    cfg_lines_m1;
  logic [LO_W-1:0]    cfg_words_m1;
  logic [ADDR_W-1:0]  cfg_src_base;
  logic [ADDR_W-1:0]  cfg_dst_base;
  logic [ADDR_W-1:0]  cfg_dst_offset;
  logic [NUM_REQ-1:0] req_lines;
  logic               bus_grant;
  logic [ADDR_W-1:0]  src_addr;
  logic [ADDR_W-1:0]  dst_addr;
  logic [1:0]         mem_space;
  logic               xfer_strobe;
  logic               ch_active;
  logic               done_irq;

  dma2d_channel #(
    .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .LO_W(LO_W), .HI_W(HI_W), .SYNC_STAGES(0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
    .cfg_irq_en(cfg_irq_en), .cfg_req_sel(cfg_req_sel), .cfg_space(cfg_space),
    .cfg_lines_m1(cfg_lines_m1), .cfg_words_m1(cfg_words_m1),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_dst_offset(cfg_dst_offset), .req_lines(req_lines), .bus_grant(bus_grant),
    .src_addr(src_addr), .dst_addr(dst_addr), .mem_space(mem_space),
    .xfer_strobe(xfer_strobe), .ch_active(ch_active), .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Bench model of the expected transfer sequence
  logic [ADDR_W-1:0] exp_src, exp_dst, m_off;
  int  m_lo, m_hi, lo_left, hi_left;
  bit  m_irq_en;
  int  words_seen, lines_started;
  bit  block_done, mon_on;
  int  irq_chk;
  int  grant_pct;
  logic [ADDR_W-1:0] prev_src, prev_dst;
  bit  prev_xfer, prev_load, prev_valid;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint words_in_block(input int lo, input int hi);
    return longint'(lo + 1) * longint'(hi + 1);
  endfunction

  // Monitor: samples at the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_valid && !prev_xfer && !prev_load) begin
        chk(src_addr == prev_src && dst_addr == prev_dst, "R4", "addr hold",
            {src_addr, dst_addr}, {prev_src, prev_dst});
      end
      if (xfer_strobe) begin
        chk(bus_grant == 1'b1, "R4", "strobe without grant", bus_grant, 1);
        chk(!block_done, "R9", "word after block end", words_seen, 0);
        chk(src_addr == exp_src, "R5", "source address", src_addr, exp_src);
        chk(dst_addr == exp_dst, "R6", "destination address", dst_addr, exp_dst);
        if (lo_left == m_lo) lines_started++;
        words_seen++;
        exp_src = exp_src + 1'b1;
        if (lo_left == 0) begin
          exp_dst = exp_dst + m_off;
          lo_left = m_lo;
          if (hi_left == 0) begin
            block_done = 1'b1;
            irq_chk    = 1;
          end else begin
            hi_left--;
          end
        end else begin
          exp_dst = exp_dst + 1'b1;
          lo_left--;
        end
      end else if (irq_chk == 1) begin
        chk(done_irq == m_irq_en, "R9", "irq pulse", done_irq, m_irq_en);
        chk(ch_active == 1'b0, "R9", "active after block", ch_active, 0);
        irq_chk = 2;
      end else if (irq_chk == 2) begin
        chk(done_irq == 1'b0, "R9", "irq second cycle", done_irq, 0);
        irq_chk = 0;
      end
      prev_src   = src_addr;
      prev_dst   = dst_addr;
      prev_xfer  = xfer_strobe;
      prev_load  = cfg_load;
      prev_valid = 1'b1;
    end
  end

  // Grant driver
  initial begin
    bus_grant = 1'b0;
    forever begin
      @(posedge clk); #2;
      bus_grant = (($urandom % 100) < grant_pct);
    end
  end

  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic configure(input logic [ADDR_W-1:0] src, input logic [ADDR_W-1:0] dst,
                           input logic [ADDR_W-1:0] off, input int lo, input int hi,
                           input int sel, input logic [1:0] space,
                           input bit irq_en, input bit en);
    @(posedge clk); #2;
    cfg_src_base   = src;
    cfg_dst_base   = dst;
    cfg_dst_offset = off;
    cfg_words_m1   = LO_W'(lo);
    cfg_lines_m1   = HI_W'(hi);
    cfg_req_sel    = SEL_W'(sel);
    cfg_space      = space;
    cfg_irq_en     = irq_en;
    cfg_enable     = en;
    cfg_load       = 1'b1;
    exp_src = src; exp_dst = dst; m_off = off;
    m_lo = lo; m_hi = hi; lo_left = lo; hi_left = hi; m_irq_en = irq_en;
    words_seen = 0; lines_started = 0; block_done = 1'b0; irq_chk = 0;
    @(posedge clk); #2;
    cfg_load = 1'b0;
  endtask

  task automatic pulse_req(input int idx);
    req_lines[idx] = 1'b1;
    @(posedge clk); #2;
    req_lines[idx] = 1'b0;
  endtask

  // Runs one full block with hi+1 requests, some issued in mid-line
  task automatic run_block(input int sel, input string tag);
    for (int i = 0; i <= m_hi; i++) begin
      int guard;
      pulse_req(sel);
      guard = 0;
      while (lines_started <= i && guard < 2000) begin
        step_n(1); guard++;
      end
      if (guard >= 2000) begin
        chk(1'b0, tag, "line did not start", lines_started, i + 1);
        return;
      end
      if (($urandom % 2) == 0) begin
        // wait for the line to finish before the next request
        guard = 0;
        while (lo_left != m_lo && guard < 2000) begin
          step_n(1); guard++;
        end
      end
    end
    begin
      int guard = 0;
      while (!block_done && guard < 4000) begin
        step_n(1); guard++;
      end
    end
    step_n(3);
    chk(longint'(words_seen) == words_in_block(m_lo, m_hi), "R7", {tag, " word count"},
        words_seen, words_in_block(m_lo, m_hi));
    chk(lines_started == m_hi + 1, "R8", {tag, " lines run"}, lines_started, m_hi + 1);
    chk(ch_active == 1'b0, "R9", {tag, " channel off"}, ch_active, 0);
    pulse_req(sel);
    step_n(8);
    chk(longint'(words_seen) == words_in_block(m_lo, m_hi), "R9", {tag, " no word after end"},
        words_seen, words_in_block(m_lo, m_hi));
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cfg_load = 1'b0; cfg_enable = 1'b0; cfg_irq_en = 1'b0;
    cfg_req_sel = '0; cfg_space = '0; cfg_lines_m1 = '0; cfg_words_m1 = '0;
    cfg_src_base = '0; cfg_dst_base = '0; cfg_dst_offset = '0; req_lines = '0;
    grant_pct = 100; mon_on = 1'b0; prev_valid = 1'b0;
    exp_src = '0; exp_dst = '0; m_off = '0; m_lo = 0; m_hi = 0; lo_left = 0; hi_left = 0;
    m_irq_en = 1'b0; words_seen = 0; lines_started = 0; block_done = 1'b0; irq_chk = 0;
    step_n(3);
    @(negedge clk);
    chk(ch_active == 0 && xfer_strobe == 0 && done_irq == 0, "R1", "reset outputs",
        {ch_active, xfer_strobe, done_irq}, 0);
    chk(src_addr == 0 && dst_addr == 0, "R1", "reset addresses", {src_addr, dst_addr}, 0);
    rst_n = 1'b1;
    step_n(2);
    mon_on = 1'b1;

    // R2 / R10: load and observe
    configure(24'h001000, 24'h00FF01, 24'hFFFFFE, 2, 3, 10, 2'b01, 1'b1, 1'b1);
    @(negedge clk);
    chk(ch_active == 1'b1, "R2", "active after load", ch_active, 1);
    chk(src_addr == 24'h001000, "R2", "source base", src_addr, 24'h001000);
    chk(dst_addr == 24'h00FF01, "R2", "destination base", dst_addr, 24'h00FF01);
    chk(mem_space == 2'b01, "R10", "memory space", mem_space, 1);
    step_n(1);

    // R3: pulses on unselected lines are ignored
    pulse_req(3); pulse_req(11); pulse_req(31);
    step_n(6);
    chk(words_seen == 0, "R3", "unselected request", words_seen, 0);

    // R6: three-register group, rewind by -2
    run_block(10, "R6 three-reg");

    // R6: two-register group, rewind by -1, partial grant
    grant_pct = 60;
    configure(24'h000200, 24'h00FF02, 24'hFFFFFF, 1, 4, 7, 2'b10, 1'b0, 1'b1);
    @(negedge clk);
    chk(mem_space == 2'b10, "R10", "memory space 2", mem_space, 2);
    run_block(7, "R6 two-reg");

    // R7: single-word lines, single-line block
    grant_pct = 100;
    configure(24'h000010, 24'h000020, 24'h000000, 0, 5, 0, 2'b00, 1'b1, 1'b1);
    run_block(0, "R7 one-word lines");
    configure(24'h000030, 24'h000040, 24'hFFFFFD, 3, 0, 31, 2'b11, 1'b1, 1'b1);
    run_block(31, "R7 one-line block");

    // R5: address wrap at the top of the address space
    configure(24'hFFFFFE, 24'hFFFFFF, 24'hFFFFFF, 1, 2, 5, 2'b00, 1'b0, 1'b1);
    run_block(5, "R5 wrap");

    // R2: disabled channel moves nothing
    configure(24'h000100, 24'h000100, 24'hFFFFFF, 1, 1, 4, 2'b00, 1'b1, 1'b0);
    @(negedge clk);
    chk(ch_active == 1'b0, "R2", "disabled load", ch_active, 0);
    step_n(1);
    pulse_req(4);
    step_n(8);
    chk(words_seen == 0, "R2", "disabled channel words", words_seen, 0);

    // Random blocks
    for (int b = 0; b < 24; b++) begin
      int lo = $urandom % 4;
      int hi = $urandom % 8;
      int sel = $urandom % NUM_REQ;
      logic [ADDR_W-1:0] off;
      off = (($urandom % 3) == 0) ? ADDR_W'($signed($urandom % 17) - 8) : ADDR_W'(-lo);
      grant_pct = 40 + ($urandom % 61);
      configure(ADDR_W'($urandom), ADDR_W'($urandom), off, lo, hi, sel,
                2'($urandom), 1'($urandom), 1'b1);
      @(negedge clk);
      chk(mem_space == cfg_space, "R10", "random memory space", mem_space, cfg_space);
      run_block(sel, "R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule